// File: doc/BRIEF.md
# Fault shutdown and reset pulse controller

This block turns protection events into shutdown commands for three regulator channels and for the motor bridges, and drives an active-low reset output. Each event arrives as a single-cycle digital pulse (regulator channel fault, motor overcurrent, over-temperature). Each one is captured on the clock and held until its own release condition, so the shortest pulse still takes effect.

Per-channel selective bits narrow a regulator fault from a global shutdown to an isolated channel shutdown. The regulators are released later by a rising edge of the sleep input. A 3-bit thermal handling code picks whether an over-temperature event shuts down everything or only the motor bridges. Motor overcurrent stops the bridges and emits one timed low pulse on the reset output. When channels B and C run as one paralleled converter, the channel C selective bit has no effect.

Top module: `fault_shutdown_ctrl`

## Requirements
- R1: After reset, all regulator shutdowns and the motor shutdown are 0, and `reset_n` is 1.
- R2: A one-cycle fault on regulator channel i (`reg_fault` bit i; bit 0 = A, 1 = B, 2 = C) with its `sel_shut` bit clear gives, in the cycle after the edge that samples it, `reg_off` = 3'b111, `motor_off` = 1 and `reset_n` = 0. These hold until `rst_n`, and a sleep rising edge does not release them.
- R3: A one-cycle `motor_oc` gives `motor_off` = 1 and drives `reset_n` low for exactly `PULSE_CYC` cycles, starting the cycle after it is sampled. `reg_off` is unchanged.
- R4: A further `motor_oc` while the reset pulse is running does not lengthen it.
- R5: Over-temperature with `therm_mode` 3'b000, or with any code other than 3'b001 and 3'b010, acts as R2.
- R6: With `sel_shut` bit i set, a channel i fault sets only `reg_off` bit i. `reset_n` stays 1 and `motor_off` stays 0.
- R7: A selective channel shutdown is cleared by the edge that first samples `sleep_n` at 1 after 0. A falling edge of `sleep_n` does not clear it.
- R8: While a selective shutdown is active, a fault on a channel whose bit is clear applies R2.
- R9: Over-temperature with `therm_mode` 3'b001 sets only `motor_off`, with `reset_n` held at 1. With 3'b010 it sets only `motor_off` and also emits the R3 reset pulse.
- R10: A motor shutdown caused by R3 or R9 is released by a sleep rising edge or by `supply_low` being sampled at 1.
- R11: With `par_mode` = 1, `sel_shut` bit 2 is ignored, so a channel C fault applies R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Sleep pin level; its rising edge releases latched shutdowns |
| supply_low | input | 1 | Supply collapse indication, releases motor shutdown |
| par_mode | input | 1 | Channels B and C paralleled |
| sel_shut | input | 3 | Selective-shutdown enable per channel (0=A, 1=B, 2=C) |
| therm_mode | input | 3 | Over-temperature handling code |
| reg_fault | input | 3 | Regulator fault pulses per channel |
| motor_oc | input | 1 | Motor overcurrent pulse |
| therm_fault | input | 1 | Over-temperature pulse |
| reg_off | output | 3 | Regulator channel shutdown commands |
| motor_off | output | 1 | Motor bridge shutdown |
| reset_n | output | 1 | Active-low reset drive |

## Verification
A vector table sends one fault pulse per entry from a fresh reset. The entries cover each channel with its selective bit clear and set, channel C with and without paralleling, and over-temperature under each thermal code. Together they tell a global shutdown apart from an isolated one and a held reset apart from a pulse. Directed sequences then measure the reset pulse width, retrigger the pulse midway and escalate a selective shutdown into a global one. They also separate the release paths: sleep rising versus falling, and supply collapse versus reset only.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [2:0] {
    TM_FULL        = 3'b000,
    TM_MOTOR_QUIET = 3'b001,
    TM_MOTOR_PULSE = 3'b010
  } therm_mode_e;
endpackage

// File: rtl/fsc_rise.sv
module fsc_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic q_q, q_d;

  always_comb q_d = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b1;
    else        q_q <= q_d;
  end

  assign rise = din & ~q_q;
endmodule

// File: rtl/fsc_sticky.sv
module fsc_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_d;

  // set wins over a release arriving in the same cycle
  always_comb q_d = (q_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q_q[i]);
  end
endmodule

// File: rtl/fsc_pulse.sv
module fsc_pulse #(
  parameter int PULSE_CYC = 256000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (busy)      cnt_d = cnt_q - CW'(1);
    else if (trig) cnt_d = CW'(PULSE_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = busy;

  assert_pulse_no_extend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/fault_shutdown_ctrl.sv
module fault_shutdown_ctrl #(
  parameter int NCH       = 3,
  parameter int PULSE_CYC = 256000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sleep_n,
  input  logic           supply_low,
  input  logic           par_mode,
  input  logic [NCH-1:0] sel_shut,
  input  logic [2:0]     therm_mode,
  input  logic [NCH-1:0] reg_fault,
  input  logic           motor_oc,
  input  logic           therm_fault,
  output logic [NCH-1:0] reg_off,
  output logic           motor_off,
  output logic           reset_n
);
  import fsc_pkg::*;

  localparam int PAR_IDX = NCH - 1;

  logic [NCH-1:0] eff_sel, chan_set, chan_q;
  logic           sleep_rise, glob_set, glob_q;
  logic           th_quiet, th_pulse, th_full;
  logic           mot_set, mot_clr, mot_q;
  logic           pulse_trig, pulse_on;

  always_comb begin
    eff_sel = sel_shut;
    if (par_mode) eff_sel[PAR_IDX] = 1'b0;
  end

  assign th_quiet   = (therm_mode == TM_MOTOR_QUIET);
  assign th_pulse   = (therm_mode == TM_MOTOR_PULSE);
  assign th_full    = ~th_quiet & ~th_pulse;

  assign chan_set   = reg_fault & eff_sel;
  assign glob_set   = (|(reg_fault & ~eff_sel)) | (therm_fault & th_full);
  assign mot_set    = motor_oc | (therm_fault & ~th_full);
  assign mot_clr    = sleep_rise | supply_low;
  assign pulse_trig = motor_oc | (therm_fault & th_pulse);

  fsc_rise u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sleep_n),
    .rise (sleep_rise)
  );

  fsc_sticky #(.W(NCH)) u_chan (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (chan_set),
    .clr  ({NCH{sleep_rise}}),
    .q    (chan_q)
  );

  fsc_sticky #(.W(1)) u_glob (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (glob_set),
    .clr  (1'b0),
    .q    (glob_q)
  );

  fsc_sticky #(.W(1)) u_mot (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (mot_set),
    .clr  (mot_clr),
    .q    (mot_q)
  );

  fsc_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (pulse_trig),
    .active(pulse_on)
  );

  assign reg_off   = {NCH{glob_q}} | chan_q;
  assign motor_off = glob_q | mot_q;
  assign reset_n   = ~(glob_q | pulse_on);

  assert_global_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    glob_q |=> (glob_q && !reset_n && (&reg_off) && motor_off));

  assert_motor_oc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    motor_oc |=> (motor_off && !reset_n));

  assert_select_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(reg_fault & eff_sel)) && !(|(reg_fault & ~eff_sel)) && !glob_q
      && !therm_fault && !motor_oc && !pulse_on) |=> reset_n);

  assert_therm_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_fault && th_quiet && reg_fault == '0 && !motor_oc && !glob_q && !pulse_on)
      |=> (reset_n && motor_off));

  assert_par_c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && reg_fault[PAR_IDX]) |=> ((&reg_off) && !reset_n));
endmodule

// File: tb/fault_shutdown_ctrl_tb.sv
module fault_shutdown_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 12;

  logic       clk = 1'b0;
  logic       rst_n, sleep_n, supply_low, par_mode, motor_oc, therm_fault;
  logic [2:0] sel_shut, therm_mode, reg_fault, reg_off;
  logic       motor_off, reset_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_shutdown_ctrl #(.NCH(3), .PULSE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .supply_low(supply_low),
    .par_mode(par_mode), .sel_shut(sel_shut), .therm_mode(therm_mode),
    .reg_fault(reg_fault), .motor_oc(motor_oc), .therm_fault(therm_fault),
    .reg_off(reg_off), .motor_off(motor_off), .reset_n(reset_n)
  );

  // [16:14] sel, [13:11] mode, [10] par, [9:7] fault, [6] oc, [5] therm,
  // [4:2] reg_off, [1] motor_off, [0] reset_n
  localparam logic [16:0] VECS [11] = '{
    {3'b000, 3'b000, 1'b0, 3'b001, 1'b0, 1'b0, 3'b111, 1'b1, 1'b0}, // R2
    {3'b001, 3'b000, 1'b0, 3'b001, 1'b0, 1'b0, 3'b001, 1'b0, 1'b1}, // R6
    {3'b010, 3'b000, 1'b0, 3'b010, 1'b0, 1'b0, 3'b010, 1'b0, 1'b1}, // R6
    {3'b100, 3'b000, 1'b0, 3'b100, 1'b0, 1'b0, 3'b100, 1'b0, 1'b1}, // R6
    {3'b100, 3'b000, 1'b1, 3'b100, 1'b0, 1'b0, 3'b111, 1'b1, 1'b0}, // R11
    {3'b000, 3'b000, 1'b0, 3'b000, 1'b0, 1'b1, 3'b111, 1'b1, 1'b0}, // R5
    {3'b000, 3'b001, 1'b0, 3'b000, 1'b0, 1'b1, 3'b000, 1'b1, 1'b1}, // R9
    {3'b000, 3'b010, 1'b0, 3'b000, 1'b0, 1'b1, 3'b000, 1'b1, 1'b0}, // R9
    {3'b000, 3'b000, 1'b0, 3'b000, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0}, // R3
    {3'b000, 3'b101, 1'b0, 3'b000, 1'b0, 1'b1, 3'b111, 1'b1, 1'b0}, // R5
    {3'b111, 3'b000, 1'b0, 3'b011, 1'b0, 1'b0, 3'b011, 1'b0, 1'b1}  // R6
  };

  function automatic string vec_tag(int i);
    case (i)
      0:       return "R2";
      4:       return "R11";
      5, 9:    return "R5";
      6, 7:    return "R9";
      8:       return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; sleep_n = 1'b1; supply_low = 1'b0; par_mode = 1'b0;
    sel_shut = '0; therm_mode = '0; reg_fault = '0; motor_oc = 1'b0;
    therm_fault = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!reset_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] outs();
    return {3'b000, reg_off, motor_off, reset_n};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    apply_reset();
    check("R1 reset state", outs(), 8'b000_001);

    for (int i = 0; i < 11; i++) begin
      apply_reset();
      sel_shut   = VECS[i][16:14];
      therm_mode = VECS[i][13:11];
      par_mode   = VECS[i][10];
      reg_fault  = VECS[i][9:7];
      motor_oc   = VECS[i][6];
      therm_fault = VECS[i][5];
      @(negedge clk);
      reg_fault = '0; motor_oc = 1'b0; therm_fault = 1'b0;
      check(vec_tag(i), outs(), {3'b000, VECS[i][4:0]});
    end

    // R3: pulse width and regulators untouched
    apply_reset();
    motor_oc = 1'b1; @(negedge clk); motor_oc = 1'b0;
    count_low(n);
    check("R3 pulse width", 8'(n), 8'(P));
    check("R3 regulators untouched", {5'b0, reg_off}, 8'b0);

    // R4: retrigger during pulse does not extend it
    apply_reset();
    motor_oc = 1'b1; @(negedge clk);
    @(negedge clk); motor_oc = 1'b0;
    count_low(n);
    check("R4 no extend", 8'(n), 8'(P - 1));

    // R10: motor shutdown persists after pulse, released by supply_low
    check("R10 motor held after pulse", {7'b0, motor_off}, 8'd1);
    supply_low = 1'b1; @(negedge clk); supply_low = 1'b0;
    check("R10 supply release", {7'b0, motor_off}, 8'd0);

    // R10: motor shutdown from thermal quiet mode released by sleep rise
    apply_reset();
    therm_mode = 3'b001; therm_fault = 1'b1; @(negedge clk); therm_fault = 1'b0;
    sleep_n = 1'b0; @(negedge clk);
    check("R10 no release while asleep", {7'b0, motor_off}, 8'd1);
    sleep_n = 1'b1; @(negedge clk);
    check("R10 sleep rise release", {7'b0, motor_off}, 8'd0);

    // R7: selective shutdown released only by sleep rising edge
    apply_reset();
    sel_shut = 3'b001; reg_fault = 3'b001; @(negedge clk); reg_fault = '0;
    sleep_n = 1'b0; @(negedge clk);
    check("R7 falling edge keeps", outs(), 8'b001_0_1);
    sleep_n = 1'b1; @(negedge clk);
    check("R7 rising edge clears", outs(), 8'b000_0_1);

    // R8: escalation from selective to global, not released by sleep (R2)
    apply_reset();
    sel_shut = 3'b001; reg_fault = 3'b001; @(negedge clk); reg_fault = '0;
    check("R8 selective first", outs(), 8'b001_0_1);
    reg_fault = 3'b010; @(negedge clk); reg_fault = '0;
    check("R8 escalated", outs(), 8'b111_1_0);
    sleep_n = 1'b0; @(negedge clk); sleep_n = 1'b1; @(negedge clk);
    supply_low = 1'b1; @(negedge clk); supply_low = 1'b0;
    repeat (P + 2) @(negedge clk);
    check("R2 global held", outs(), 8'b111_1_0);

    finish_run();
  end
endmodule